// File: doc/BRIEF.md
# Full-Duplex SPI Master Channel with Packet Stop

This block is one SPI master channel behind a narrow word-indexed register bus. Software writes bytes into a transmit FIFO and reads received bytes from a receive FIFO. A shift engine moves eight bits per transfer, most significant bit first. It drives MOSI and samples MISO on the same serial clock, so every byte sent also returns a byte.

The serial clock comes from the system clock. Each half period lasts prescaler+1 system cycles, so the SCLK frequency is the source clock divided by 2*(prescaler+1). A separate enable bit gates SCLK generation as a whole. Polarity and phase are each chosen by a control bit. Chip select is a plain register bit driven straight to the pin.

An optional packet limit halts the clock once a programmed number of bytes has been received. The programmed limit is kept in a shadow register. It only becomes active when a soft reset or a hardware reset occurs. A soft reset clears the FIFOs, the engine, the sticky error flags and the received-byte tally, and it keeps all configuration. Ready levels, sticky errors and per-source interrupt enables produce one level interrupt.

Top module: `spi_pkt_master`

## Requirements
- R1: After hardware reset, status (index 0) reads 0x200001: TX-ready (bit 0) is set, TX-done (bit 21) is set, and every other bit is clear. At the same time cs_n is 1, sclk is 0 and irq is 0.
- R2: Clock register (index 4) fields:
  - Bits 7:0 hold the prescaler, and bit 8 enables SCLK.
  - Each SCLK half period lasts prescaler+1 clock cycles.
  - When the engine is idle, SCLK rests at the polarity bit (control register bit 3).
  - While bit 8 is 0, SCLK never toggles.
- R3: Each transfer puts 8 bits on mosi, MSB first. Control register (index 3) bit 2 selects the phase:
  - With phase 0, mosi is valid on the first SCLK edge.
  - With phase 1, mosi changes on the first edge and is valid on the second.
  - An edge is a sampling edge when it is rising and polarity equals phase, or when it is falling and they differ.
- R4: Each byte sampled from miso goes into the RX FIFO. Reading the RX port (index 2) returns the bytes in arrival order in bits 7:0 and removes them from the FIFO.
- R5: Packet-count register (index 8) fields:
  - Bits 15:0 hold the count, and bit 16 enables the limit.
  - When the active limit is enabled and the number of received bytes equals the count, no new transfer starts, and status bit 20 reads 1.
- R6: Control register bit 5 is a soft reset. It loads the shadow packet count into the active limit and clears both FIFOs, the engine, the sticky errors and the received-byte tally. Every configuration register keeps its value. A packet count written without a soft reset has no effect.
- R7: Overrun handling:
  - Writing the TX port (index 1) while the TX FIFO is full sets status bit 3 (TX overrun), and the written byte is dropped.
  - A byte received while the RX FIFO is full sets status bit 5 (RX overrun), and that new byte is dropped.
- R8: Reading the RX port while the RX FIFO is empty sets status bit 4 (RX underrun).
- R9: Writing ones to the pending-clear register (index 9), bits 5:2, clears the matching sticky error bits.
- R10: Mode register (index 5) holds the TX trigger in bits 10:5 and the RX trigger in bits 16:11. Both reset to 1.
  - Status bit 0 is 1 when the free TX slots are at least the TX trigger.
  - Status bit 1 is 1 when the RX level is at least the RX trigger.
- R11: irq is 1 exactly when some status bit 0 to 5 is set and its enable bit (same position in index 7) is set.
- R12: Bit 0 of index 6 drives cs_n directly: 0 means active and 1 means inactive.
- R13: Status bit 21 (TX done) is 1 only when the TX FIFO is empty and the engine is idle.
- R14: Control bit 0 enables TX: when it is 0, no transfer starts. Control bit 1 enables RX: when it is 0, received bytes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the SCLK source |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX on index 2) |
| bus_idx | input | 4 | Register word index |
| bus_wdata | input | 17 | Write data |
| bus_rdata | output | 22 | Combinational read data for bus_idx |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the channel with its default FIFO depth of 4 and an 8-bit prescaler. With a depth of 4, both overrun cases and the trigger crossings can be reached in a handful of bus writes. Prescaler values from 0 to 5 keep each byte short while still showing the half-period stretching. MISO is looped back from MOSI, and the test bytes are not bit palindromes. Because of that, the receive path, the wire order and both phase settings can each be checked against the byte that was sent.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned WD_W  = 17;
  localparam int unsigned RD_W  = 22;

  localparam logic [IDX_W-1:0] RG_STAT = 4'd0;
  localparam logic [IDX_W-1:0] RG_TXD  = 4'd1;
  localparam logic [IDX_W-1:0] RG_RXD  = 4'd2;
  localparam logic [IDX_W-1:0] RG_CHAN = 4'd3;
  localparam logic [IDX_W-1:0] RG_CLK  = 4'd4;
  localparam logic [IDX_W-1:0] RG_MODE = 4'd5;
  localparam logic [IDX_W-1:0] RG_SSEL = 4'd6;
  localparam logic [IDX_W-1:0] RG_IEN  = 4'd7;
  localparam logic [IDX_W-1:0] RG_PCNT = 4'd8;
  localparam logic [IDX_W-1:0] RG_CLR  = 4'd9;

  localparam int unsigned CH_TXEN = 0;
  localparam int unsigned CH_RXEN = 1;
  localparam int unsigned CH_PHA  = 2;
  localparam int unsigned CH_POL  = 3;
  localparam int unsigned CH_SRST = 5;

  localparam int unsigned ST_TXO  = 3;
  localparam int unsigned ST_RXU  = 4;
  localparam int unsigned ST_RXO  = 5;
  localparam int unsigned ST_HIT  = 20;
  localparam int unsigned ST_DONE = 21;

  typedef struct packed {
    logic rx_ovr;
    logic rx_und;
    logic tx_ovr;
  } err_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem_q[rp_q];
  assign count   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (clr) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem_q[wp_q] <= din;
  end

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (push && full && !pop) |=> $stable(cnt_q));
endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] presc,
  output logic          tick
);
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == presc);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
  parameter int unsigned BITS = 8,
  localparam int unsigned EW  = $clog2(2 * BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            start,
  input  logic [BITS-1:0] tx_byte,
  input  logic            cpol,
  input  logic            cpha,
  input  logic            tick,
  input  logic            miso,
  output logic            busy,
  output logic            done,
  output logic [BITS-1:0] rx_byte,
  output logic            sclk,
  output logic            mosi
);
  logic            busy_q, busy_d, done_q, done_d, sck_q, sck_d, samp;
  logic [EW-1:0]   idx_q, idx_d;
  logic [BITS-1:0] txs_q, txs_d, rxs_q, rxs_d;

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rxs_q;
  assign mosi    = txs_q[BITS-1];
  assign sclk    = busy_q ? sck_q : cpol;
  assign samp    = cpha ? idx_q[0] : !idx_q[0];

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    sck_d  = sck_q;
    idx_d  = idx_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    if (clr) begin
      busy_d = 1'b0;
      sck_d  = cpol;
      idx_d  = '0;
    end else if (start && !busy_q) begin
      busy_d = 1'b1;
      sck_d  = cpol;
      idx_d  = '0;
      txs_d  = tx_byte;
    end else if (busy_q && tick) begin
      sck_d = !sck_q;
      idx_d = idx_q + 1'b1;
      if (samp) rxs_d = {rxs_q[BITS-2:0], miso};
      else if (!(cpha && idx_q == '0)) txs_d = {txs_q[BITS-2:0], 1'b0};
      if (idx_q == EW'(2 * BITS - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      idx_q  <= '0;
      txs_q  <= '0;
      rxs_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      sck_q  <= sck_d;
      idx_q  <= idx_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
    end
  end

  // R2
  sclk_home_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    done_q |-> (sck_q == cpol));
  // R2
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (busy_q && !tick) |=> $stable(sck_q));
endmodule

// File: rtl/spi_pkt_master.sv
module spi_pkt_master
  import spi_pkt_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned PRESC_W    = 8,
  parameter int unsigned PCNT_W     = 16,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned TRIG_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [WD_W-1:0]  bus_wdata,
  output logic [RD_W-1:0]  bus_rdata,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic             irq
);
  logic [3:0]          ch_q, ch_d;
  logic [PRESC_W:0]    ck_q, ck_d;
  logic [TRIG_W-1:0]   ttrig_q, ttrig_d, rtrig_q, rtrig_d;
  logic                ss_q, ss_d;
  logic [5:0]          ien_q, ien_d;
  logic [PCNT_W:0]     psh_q, psh_d, pact_q, pact_d;
  logic [PCNT_W-1:0]   rcvd_q, rcvd_d;
  err_t                err_q, err_d;

  logic wr_chan, srst, wr_txd, rd_rxd, hit, eng_start, eng_busy, eng_done, tick;
  logic tx_full, tx_empty, rx_full, rx_empty, rx_push, tx_rdy, rx_rdy, tx_done;
  logic [7:0]    tx_dout, rx_dout, eng_rx;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [RD_W-1:0] stat;

  assign wr_chan = bus_wr && (bus_idx == RG_CHAN);
  assign srst    = wr_chan && bus_wdata[CH_SRST];
  assign wr_txd  = bus_wr && (bus_idx == RG_TXD);
  assign rd_rxd  = bus_rd && (bus_idx == RG_RXD);
  assign hit     = pact_q[PCNT_W] && (rcvd_q == pact_q[PCNT_W-1:0]);
  assign eng_start = !eng_busy && !eng_done && !srst && ch_q[CH_TXEN] &&
                     ck_q[PRESC_W] && !tx_empty && !hit;
  assign rx_push = eng_done && ch_q[CH_RXEN];

  spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(srst), .push(wr_txd), .pop(eng_start),
    .din(bus_wdata[7:0]), .dout(tx_dout), .count(tx_cnt), .full(tx_full),
    .empty(tx_empty));

  spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(srst), .push(rx_push), .pop(rd_rxd),
    .din(eng_rx), .dout(rx_dout), .count(rx_cnt), .full(rx_full),
    .empty(rx_empty));

  spi_sclk_div #(.PW(PRESC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(eng_busy && !srst),
    .presc(ck_q[PRESC_W-1:0]), .tick(tick));

  spi_shift_eng #(.BITS(8)) u_eng (
    .clk(clk), .rst_n(rst_n), .clr(srst), .start(eng_start), .tx_byte(tx_dout),
    .cpol(ch_q[CH_POL]), .cpha(ch_q[CH_PHA]), .tick(tick), .miso(miso),
    .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx), .sclk(sclk), .mosi(mosi));

  assign tx_rdy  = (7'(FIFO_DEPTH) - 7'(tx_cnt)) >= 7'(ttrig_q);
  assign rx_rdy  = 7'(rx_cnt) >= 7'(rtrig_q);
  assign tx_done = tx_empty && !eng_busy && !eng_done;

  always_comb begin
    stat          = '0;
    stat[0]       = tx_rdy;
    stat[1]       = rx_rdy;
    stat[ST_TXO]  = err_q.tx_ovr;
    stat[ST_RXU]  = err_q.rx_und;
    stat[ST_RXO]  = err_q.rx_ovr;
    stat[ST_HIT]  = hit;
    stat[ST_DONE] = tx_done;
  end

  assign irq  = |(ien_q & stat[5:0]);
  assign cs_n = ss_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_idx)
      RG_STAT: bus_rdata = stat;
      RG_RXD:  bus_rdata = RD_W'(rx_dout);
      RG_CHAN: bus_rdata = RD_W'(ch_q);
      RG_CLK:  bus_rdata = RD_W'(ck_q);
      RG_MODE: bus_rdata = RD_W'({rtrig_q, ttrig_q, 5'b0});
      RG_SSEL: bus_rdata = RD_W'(ss_q);
      RG_IEN:  bus_rdata = RD_W'(ien_q);
      RG_PCNT: bus_rdata = RD_W'(psh_q);
      default: bus_rdata = '0;
    endcase
  end

  always_comb begin
    ch_d    = ch_q;
    ck_d    = ck_q;
    ttrig_d = ttrig_q;
    rtrig_d = rtrig_q;
    ss_d    = ss_q;
    ien_d   = ien_q;
    psh_d   = psh_q;
    pact_d  = pact_q;
    rcvd_d  = rcvd_q;
    err_d   = err_q;
    if (bus_wr) begin
      case (bus_idx)
        RG_CHAN: ch_d = bus_wdata[3:0];
        RG_CLK:  ck_d = bus_wdata[PRESC_W:0];
        RG_MODE: begin
          ttrig_d = bus_wdata[10:5];
          rtrig_d = bus_wdata[16:11];
        end
        RG_SSEL: ss_d  = bus_wdata[0];
        RG_IEN:  ien_d = bus_wdata[5:0];
        RG_PCNT: psh_d = bus_wdata[PCNT_W:0];
        RG_CLR: begin
          if (bus_wdata[ST_TXO]) err_d.tx_ovr = 1'b0;
          if (bus_wdata[ST_RXU]) err_d.rx_und = 1'b0;
          if (bus_wdata[ST_RXO]) err_d.rx_ovr = 1'b0;
        end
        default: ;
      endcase
    end
    if (wr_txd && tx_full)   err_d.tx_ovr = 1'b1;
    if (rd_rxd && rx_empty)  err_d.rx_und = 1'b1;
    if (rx_push && rx_full)  err_d.rx_ovr = 1'b1;
    if (eng_done)            rcvd_d = rcvd_q + 1'b1;
    if (srst) begin
      err_d  = '0;
      rcvd_d = '0;
      pact_d = psh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q    <= '0;
      ck_q    <= '0;
      ttrig_q <= TRIG_W'(1);
      rtrig_q <= TRIG_W'(1);
      ss_q    <= 1'b1;
      ien_q   <= '0;
      psh_q   <= '0;
      pact_q  <= '0;
      rcvd_q  <= '0;
      err_q   <= '0;
    end else begin
      ch_q    <= ch_d;
      ck_q    <= ck_d;
      ttrig_q <= ttrig_d;
      rtrig_q <= rtrig_d;
      ss_q    <= ss_d;
      ien_q   <= ien_d;
      psh_q   <= psh_d;
      pact_q  <= pact_d;
      rcvd_q  <= rcvd_d;
      err_q   <= err_d;
    end
  end

  // R5
  pkt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (hit && !eng_busy) |=> !eng_busy);
  // R14
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    !ch_q[CH_TXEN] |=> !$rose(eng_busy));
  // R8
  rx_under_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (rd_rxd && rx_empty) |=> err_q.rx_und);
endmodule

// File: tb/tb_spi_pkt_master.sv
module tb_spi_pkt_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_idx = '0;
  logic [16:0] bus_wdata = '0;
  logic [21:0] bus_rdata;
  logic sclk, mosi, cs_n, irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  spi_pkt_master dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(mosi), .cs_n(cs_n), .irq(irq));

  // wire-side monitor
  logic mon_pol = 1'b0, mon_pha = 1'b0;
  logic [7:0] cap = '0;
  int gap = 0, last_gap = 0, toggles = 0;
  logic prev_sclk = 1'b0;
  always @(posedge sclk) if (mon_pol == mon_pha) cap = {cap[6:0], mosi};
  always @(negedge sclk) if (mon_pol != mon_pha) cap = {cap[6:0], mosi};
  always @(negedge clk) begin
    if (sclk !== prev_sclk) begin last_gap = gap; gap = 1; toggles++; end
    else gap++;
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [16:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_idx = idx; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [21:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_idx = idx; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_done();
    logic [21:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(4'd0, s);
      if (s[21]) break;
    end
  endtask

  // {pol, pha, presc[5:0], byte[7:0]}
  localparam logic [15:0] VEC [5] = '{
    {1'b0, 1'b0, 6'd0, 8'hA6}, {1'b0, 1'b1, 6'd1, 8'h3D},
    {1'b1, 1'b0, 6'd2, 8'h82}, {1'b1, 1'b1, 6'd3, 8'h71},
    {1'b0, 1'b0, 6'd5, 8'h01}};

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [21:0] s;
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(4'd0, s);
    chk(s == 22'h200001, "R1 status", s, 22'h200001);
    chk(cs_n == 1'b1 && sclk == 1'b0 && irq == 1'b0, "R1 pins", {cs_n, sclk, irq}, 3'b100);

    // table-driven transfers with loopback
    foreach (VEC[i]) begin
      mon_pol = VEC[i][15]; mon_pha = VEC[i][14];
      wr(4'd3, 17'(32 | (VEC[i][15] << 3) | (VEC[i][14] << 2) | 3));
      wr(4'd4, 17'(256 + VEC[i][13:8]));
      wr(4'd1, 17'(VEC[i][7:0]));
      wait_done();
      chk(cap == VEC[i][7:0], "R3 wire byte", cap, VEC[i][7:0]);
      chk(last_gap == VEC[i][13:8] + 1, "R2 half period", last_gap, VEC[i][13:8] + 1);
      chk(sclk == VEC[i][15], "R2 idle level", sclk, VEC[i][15]);
      rd(4'd2, s);
      chk(s[7:0] == VEC[i][7:0], "R4 rx byte", s[7:0], VEC[i][7:0]);
    end
    mon_pol = 1'b0; mon_pha = 1'b0;

    // R12 chip select
    wr(4'd6, 17'd0);
    chk(cs_n == 1'b0, "R12 cs active", cs_n, 0);
    wr(4'd6, 17'd1);
    chk(cs_n == 1'b1, "R12 cs inactive", cs_n, 1);

    // clock disabled: nothing moves
    wr(4'd3, 17'h23);
    wr(4'd4, 17'd0);
    t0 = toggles;
    wr(4'd1, 17'h11); wr(4'd1, 17'h22); wr(4'd1, 17'h33);
    repeat (50) @(negedge clk);
    chk(toggles == t0, "R2 clock gated", toggles - t0, 0);
    rd(4'd0, s);
    chk(s[21] == 1'b0, "R13 not done with data queued", s[21], 0);
    wr(4'd5, 17'(2 << 5 | 1 << 11));
    rd(4'd0, s);
    chk(s[0] == 1'b0, "R10 tx ready below trigger", s[0], 0);
    wr(4'd1, 17'h44); wr(4'd1, 17'h55);
    rd(4'd0, s);
    chk(s[3] == 1'b1, "R7 tx overrun", s[3], 1);
    wr(4'd7, 17'h08);
    chk(irq == 1'b1, "R11 irq on enabled source", irq, 1);
    wr(4'd9, 17'h08);
    rd(4'd0, s);
    chk(s[3] == 1'b0 && irq == 1'b0, "R9 pending clear", {s[3], irq}, 0);
    wr(4'd7, 17'h00);
    wr(4'd3, 17'h23);
    rd(4'd0, s);
    chk(s[21] == 1'b1, "R6 soft reset empties tx", s[21], 1);
    rd(4'd5, s);
    chk(s[10:5] == 6'd2, "R6 config kept", s[10:5], 2);

    // rx trigger and overrun
    wr(4'd5, 17'(1 << 5 | 2 << 11));
    wr(4'd4, 17'h100);
    wr(4'd1, 17'h11); wait_done();
    rd(4'd0, s);
    chk(s[1] == 1'b0, "R10 rx below trigger", s[1], 0);
    wr(4'd1, 17'h22); wr(4'd1, 17'h33); wr(4'd1, 17'h44); wait_done();
    rd(4'd0, s);
    chk(s[1] == 1'b1, "R10 rx at trigger", s[1], 1);
    wr(4'd1, 17'h55); wait_done();
    rd(4'd0, s);
    chk(s[5] == 1'b1, "R7 rx overrun", s[5], 1);
    for (int k = 1; k <= 4; k++) begin
      rd(4'd2, s);
      chk(s[7:0] == 8'(k * 17), "R7 rx order kept, newest dropped", s[7:0], k * 17);
    end
    rd(4'd2, s);
    rd(4'd0, s);
    chk(s[4] == 1'b1, "R8 rx underrun", s[4], 1);

    // packet count needs a soft reset
    wr(4'd5, 17'(1 << 5 | 1 << 11));
    wr(4'd3, 17'h23);
    wr(4'd8, 17'(65536 + 2));
    wr(4'd1, 17'h01); wr(4'd1, 17'h02); wr(4'd1, 17'h03); wait_done();
    rd(4'd0, s);
    chk(s[21] == 1'b1 && s[20] == 1'b0, "R6 count not yet active", s[21:20], 2);
    wr(4'd3, 17'h23);
    wr(4'd1, 17'h5A); wr(4'd1, 17'h6B); wr(4'd1, 17'h7C); wr(4'd1, 17'h8D);
    repeat (300) @(negedge clk);
    rd(4'd0, s);
    chk(s[20] == 1'b1 && s[21] == 1'b0, "R5 stopped at count", s[21:20], 1);
    rd(4'd2, s);
    chk(s[7:0] == 8'h5A, "R5 first byte", s[7:0], 8'h5A);
    rd(4'd2, s);
    chk(s[7:0] == 8'h6B, "R5 second byte", s[7:0], 8'h6B);
    rd(4'd0, s);
    chk(s[1] == 1'b0, "R5 no third byte", s[1], 0);

    // channel enables
    wr(4'd8, 17'd0);
    wr(4'd3, 17'h21);
    wr(4'd1, 17'h9E); wait_done();
    rd(4'd0, s);
    chk(s[21] == 1'b1 && s[1] == 1'b0, "R14 rx disabled discards", s[1], 0);
    wr(4'd3, 17'h22);
    t0 = toggles;
    wr(4'd1, 17'h9F);
    repeat (50) @(negedge clk);
    rd(4'd0, s);
    chk(s[21] == 1'b0 && toggles == t0, "R14 tx disabled holds", toggles - t0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule